// File: doc/BRIEF.md
# Clock Synthesizer Configuration Target on I2C

This block is the I2C target that holds the configuration registers of a clock synthesizer. It runs entirely in the system clock domain. SCL and SDA pass through two-flop synchronizers. START and STOP are found from SDA edges that occur while SCL is high. The block drives SDA only by pulling it low, through an enable output. A host first writes a register index after the address byte. It may then write one or more data bytes, or issue a repeated START and read one or more bytes. An internal pointer steps by one after every data byte in either direction.

Four registers are double-buffered: the loop control byte (index 1), the two feedback divider bytes (indices 2 and 3) and the phase adjust control byte (index 5). Host writes to these land in shadow copies, and readback returns the shadow copy. The working copies drive the configuration outputs. They change only when a command byte is written to index 8. An upper nibble of 5h copies the loop and divider group, and a lower nibble of Ah copies the phase adjust group. Both codes may appear in one byte. The other registers (indices 0, 4, 6 and 7) act on their outputs as soon as they are written. Indices 10h to 12h are read-only: they return the version, the revision and the two lock flags.

The target state machine has these states. ST_IDLE waits for a START. ST_ADDR receives the address byte. ST_ACK_ADDR acknowledges it. ST_INDEX receives the register index, and ST_ACK_INDEX acknowledges it. ST_WRITE receives a data byte, and ST_ACK_WRITE acknowledges it. ST_READ sends a data byte. ST_ACK_READ samples the host's acknowledge.

The transitions are as follows:
- A START in any state moves to ST_ADDR, and a STOP in any state moves to ST_IDLE.
- When the address matches, ST_ADDR goes to ST_ACK_ADDR; when it does not, ST_ADDR goes to ST_IDLE.
- ST_ACK_ADDR goes to ST_READ for a read address and to ST_INDEX for a write address.
- ST_INDEX goes to ST_ACK_INDEX, and ST_ACK_INDEX goes to ST_WRITE.
- ST_WRITE and ST_ACK_WRITE alternate.
- ST_READ goes to ST_ACK_READ. ST_ACK_READ returns to ST_READ after an ACK and goes to ST_IDLE after a NACK.

Top module: `clkgen_cfg_target`

## Requirements
- R1: The target answers only the 7-bit address 010011X, where X is the level of `addr_pin`. A byte with any other address gets no ACK, and the bytes that follow it until the next START have no effect.
- R2: The target drives SDA low during the ninth clock of every matching address byte, every index byte and every written data byte. SDA is first pulled low only while SCL is low.
- R3: After the index byte, each written data byte goes to the index held by the pointer, and the pointer then steps by one. Data is sent MSB first.
- R4: A repeated START with the read address returns the byte at the pointer, MSB first, and the pointer steps by one after each byte. An ACK from the host fetches the next byte. After a NACK the target releases SDA and sends nothing more.
- R5: The reset values by index are 0:41h, 1:00h, 2:FFh, 3:0Fh, 4:80h, 5:03h, 6:00h and 7:80h. Both the outputs and the readback start at these values.
- R6: A write to index 1, 2, 3 or 5 changes only the shadow copy. The readback shows the shadow value at once, but the matching output holds its working value until a commit.
- R7: A write to index 8 with upper nibble 5h copies the shadows of indices 1, 2 and 3 to their outputs. A write with lower nibble Ah copies the shadow of index 5. 5Ah does both, and any other value copies nothing.
- R8: Index 10h reads the version (parameter, default 18h) and 11h reads the revision 01h. Index 12h reads {6'b0, pll_locked, dpa_locked}. Writes to all three are ignored.
- R9: Reserved bits always read and output as 0: bits 7, 6 and 3 of index 1, and bits 7:4 of index 3.
- R10: Index 8 reads as 00h, and any unimplemented index reads as 00h. A write to an unimplemented index is acknowledged but changes nothing.
- R11: A STOP at any point returns the target to idle with SDA released, and the next transaction proceeds normally.
- R12: Writes to indices 0, 4, 6 and 7 reach their outputs directly, with no commit needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open drain) |
| addr_pin | input | 1 | Address bit 0 select |
| dpa_locked | input | 1 | Phase adjust lock flag |
| pll_locked | input | 1 | PLL lock flag |
| cfg_input | output | 8 | Index 0, input control |
| cfg_loop | output | 8 | Index 1 working copy |
| cfg_fb_lo | output | 8 | Index 2 working copy |
| cfg_fb_hi | output | 8 | Index 3 working copy |
| cfg_phase_ofs | output | 8 | Index 4, phase offset and filter select |
| cfg_phase_ctl | output | 8 | Index 5 working copy |
| cfg_out_en | output | 8 | Index 6, output enables and scalers |
| cfg_osc | output | 8 | Index 7, oscillator divider and input select |

## Verification
Four properties are checked on every cycle. A working copy holds its value unless a command write arrives. Each commit code copies exactly the group it names from the shadow. SDA is first pulled low only while SCL is low, and it is released on entry to the host-acknowledge state and after any STOP. The bench scenarios are the only evidence for address matching on both pin levels, pointer stepping across sequential writes and reads, and the reset values. They also cover the read-only and reserved values, the ignored writes, and recovery from a STOP in the middle of a byte.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_INDEX,
        ST_ACK_INDEX,
        ST_WRITE,
        ST_ACK_WRITE,
        ST_READ,
        ST_ACK_READ
    } tgt_state_e;

    localparam logic [5:0] DEV_ADDR_HI = 6'b010011;

    localparam logic [7:0] IDX_INPUT = 8'h00;
    localparam logic [7:0] IDX_LOOP  = 8'h01;
    localparam logic [7:0] IDX_FBLO  = 8'h02;
    localparam logic [7:0] IDX_FBHI  = 8'h03;
    localparam logic [7:0] IDX_POFS  = 8'h04;
    localparam logic [7:0] IDX_PCTL  = 8'h05;
    localparam logic [7:0] IDX_OEN   = 8'h06;
    localparam logic [7:0] IDX_OSC   = 8'h07;
    localparam logic [7:0] IDX_CMD   = 8'h08;
    localparam logic [7:0] IDX_VER   = 8'h10;
    localparam logic [7:0] IDX_REV   = 8'h11;
    localparam logic [7:0] IDX_STAT  = 8'h12;

    localparam logic [3:0] CMD_PLL_CODE = 4'h5;
    localparam logic [3:0] CMD_DPA_CODE = 4'hA;

    localparam logic [7:0] LOOP_KEEP = 8'h37;
    localparam logic [7:0] FBHI_KEEP = 8'h0F;

    localparam logic [7:0] RST_INPUT = 8'h41;
    localparam logic [7:0] RST_LOOP  = 8'h00;
    localparam logic [7:0] RST_FBLO  = 8'hFF;
    localparam logic [7:0] RST_FBHI  = 8'h0F;
    localparam logic [7:0] RST_POFS  = 8'h80;
    localparam logic [7:0] RST_PCTL  = 8'h03;
    localparam logic [7:0] RST_OEN   = 8'h00;
    localparam logic [7:0] RST_OSC   = 8'h80;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_d;
    logic          sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_raw};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_raw};
            scl_d    <= scl_pipe[LAST];
            sda_d    <= sda_pipe[LAST];
        end
    end

    assign scl_s     = scl_pipe[LAST];
    assign sda_s     = sda_pipe[LAST];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
    assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import clkcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    tgt_state_e state, state_n;

    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [7:0] ptr;
    logic       ack_ph;
    logic       is_read;
    logic       host_ack;

    logic [7:0] rx_next;
    logic       byte_done;
    logic       addr_ok;

    assign rx_next   = {rx_sh[6:0], sda_s};
    assign byte_done = scl_rise && (bit_cnt == 4'd7);
    assign addr_ok   = (rx_next[7:1] == {DEV_ADDR_HI, addr_sel});
    assign rd_idx    = ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (bus_stop) begin
            state_n = ST_IDLE;
        end else if (bus_start) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_n = ST_IDLE;
                ST_ADDR:      if (byte_done) state_n = addr_ok ? ST_ACK_ADDR : ST_IDLE;
                ST_ACK_ADDR:  if (scl_fall && ack_ph) state_n = is_read ? ST_READ : ST_INDEX;
                ST_INDEX:     if (byte_done) state_n = ST_ACK_INDEX;
                ST_ACK_INDEX: if (scl_fall && ack_ph) state_n = ST_WRITE;
                ST_WRITE:     if (byte_done) state_n = ST_ACK_WRITE;
                ST_ACK_WRITE: if (scl_fall && ack_ph) state_n = ST_WRITE;
                ST_READ:      if (scl_fall && bit_cnt == 4'd8) state_n = ST_ACK_READ;
                ST_ACK_READ:  if (scl_fall) state_n = host_ack ? ST_READ : ST_IDLE;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            ack_ph   <= 1'b0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bus_stop || bus_start) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                ack_ph  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_INDEX, ST_WRITE: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_next;
                            bit_cnt <= bit_cnt + 4'd1;
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                ack_ph  <= 1'b0;
                                if (state == ST_ADDR) is_read <= rx_next[0];
                                if (state == ST_INDEX) ptr <= rx_next;
                                if (state == ST_WRITE) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= rx_next;
                                    ptr     <= ptr + 8'd1;
                                end
                            end
                        end
                    end
                    ST_ACK_ADDR, ST_ACK_INDEX, ST_ACK_WRITE: begin
                        if (scl_fall) begin
                            if (!ack_ph) begin
                                sda_oe <= 1'b1;
                                ack_ph <= 1'b1;
                            end else begin
                                sda_oe  <= 1'b0;
                                ack_ph  <= 1'b0;
                                bit_cnt <= '0;
                                if (state == ST_ACK_ADDR && is_read) begin
                                    tx_sh  <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                    ptr    <= ptr + 8'd1;
                                end
                            end
                        end
                    end
                    ST_READ: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
                        if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_ACK_READ: begin
                        if (scl_rise) host_ack <= ~sda_s;
                        if (scl_fall && host_ack) begin
                            tx_sh   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            ptr     <= ptr + 8'd1;
                            bit_cnt <= '0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end

    AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == ST_IDLE) && !sda_oe); // R11

    AST_HOST_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_READ) |-> !sda_oe); // R4

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter logic [7:0] CHIP_VERSION  = 8'h18,
    parameter logic [7:0] CHIP_REVISION = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    input  logic       dpa_lock,
    input  logic       pll_lock,
    output logic [7:0] o_input,
    output logic [7:0] o_loop,
    output logic [7:0] o_fblo,
    output logic [7:0] o_fbhi,
    output logic [7:0] o_pofs,
    output logic [7:0] o_pctl,
    output logic [7:0] o_oen,
    output logic [7:0] o_osc
);
    logic [7:0] r_input, r_pofs, r_oen, r_osc;
    logic [7:0] s_loop, s_fblo, s_fbhi, s_pctl;
    logic [7:0] w_loop, w_fblo, w_fbhi, w_pctl;
    logic       cmd_wr;

    assign cmd_wr = wr_en && (wr_idx == IDX_CMD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_input <= RST_INPUT;
            r_pofs  <= RST_POFS;
            r_oen   <= RST_OEN;
            r_osc   <= RST_OSC;
            s_loop  <= RST_LOOP;
            s_fblo  <= RST_FBLO;
            s_fbhi  <= RST_FBHI;
            s_pctl  <= RST_PCTL;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_INPUT: r_input <= wr_data;
                IDX_LOOP:  s_loop  <= wr_data & LOOP_KEEP;
                IDX_FBLO:  s_fblo  <= wr_data;
                IDX_FBHI:  s_fbhi  <= wr_data & FBHI_KEEP;
                IDX_POFS:  r_pofs  <= wr_data;
                IDX_PCTL:  s_pctl  <= wr_data;
                IDX_OEN:   r_oen   <= wr_data;
                IDX_OSC:   r_osc   <= wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_loop <= RST_LOOP;
            w_fblo <= RST_FBLO;
            w_fbhi <= RST_FBHI;
        end else if (cmd_wr && wr_data[7:4] == CMD_PLL_CODE) begin
            w_loop <= s_loop;
            w_fblo <= s_fblo;
            w_fbhi <= s_fbhi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_pctl <= RST_PCTL;
        end else if (cmd_wr && wr_data[3:0] == CMD_DPA_CODE) begin
            w_pctl <= s_pctl;
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_INPUT: rd_data = r_input;
            IDX_LOOP:  rd_data = s_loop;
            IDX_FBLO:  rd_data = s_fblo;
            IDX_FBHI:  rd_data = s_fbhi;
            IDX_POFS:  rd_data = r_pofs;
            IDX_PCTL:  rd_data = s_pctl;
            IDX_OEN:   rd_data = r_oen;
            IDX_OSC:   rd_data = r_osc;
            IDX_VER:   rd_data = CHIP_VERSION;
            IDX_REV:   rd_data = CHIP_REVISION;
            IDX_STAT:  rd_data = {6'b0, pll_lock, dpa_lock};
            default:   rd_data = 8'h00;
        endcase
    end

    assign o_input = r_input;
    assign o_loop  = w_loop;
    assign o_fblo  = w_fblo;
    assign o_fbhi  = w_fbhi;
    assign o_pofs  = r_pofs;
    assign o_pctl  = w_pctl;
    assign o_oen   = r_oen;
    assign o_osc   = r_osc;

    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(w_loop) && $stable(w_fblo) && $stable(w_fbhi) && $stable(w_pctl)); // R6

    AST_PLL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[7:4] == CMD_PLL_CODE) |=>
        (w_loop == $past(s_loop)) && (w_fblo == $past(s_fblo)) && (w_fbhi == $past(s_fbhi))); // R7

    AST_DPA_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[3:0] == CMD_DPA_CODE) |=> (w_pctl == $past(s_pctl))); // R7

endmodule

// File: rtl/clkgen_cfg_target.sv
module clkgen_cfg_target #(
    parameter int         SYNC_STAGES   = 2,
    parameter logic [7:0] CHIP_VERSION  = 8'h18,
    parameter logic [7:0] CHIP_REVISION = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic       addr_pin,
    input  logic       dpa_locked,
    input  logic       pll_locked,
    output logic [7:0] cfg_input,
    output logic [7:0] cfg_loop,
    output logic [7:0] cfg_fb_lo,
    output logic [7:0] cfg_fb_hi,
    output logic [7:0] cfg_phase_ofs,
    output logic [7:0] cfg_phase_ctl,
    output logic [7:0] cfg_out_en,
    output logic [7:0] cfg_osc
);
    logic       scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] rd_data, rd_idx, wr_idx, wr_data;
    logic       wr_en;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_target_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_sel  (addr_pin),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_pull)
    );

    clkcfg_regfile #(
        .CHIP_VERSION  (CHIP_VERSION),
        .CHIP_REVISION (CHIP_REVISION)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .dpa_lock (dpa_locked),
        .pll_lock (pll_locked),
        .o_input  (cfg_input),
        .o_loop   (cfg_loop),
        .o_fblo   (cfg_fb_lo),
        .o_fbhi   (cfg_fb_hi),
        .o_pofs   (cfg_phase_ofs),
        .o_pctl   (cfg_phase_ctl),
        .o_oen    (cfg_out_en),
        .o_osc    (cfg_osc)
    );

endmodule

// File: tb/test_clkgen_cfg_target.sv
module test_clkgen_cfg_target;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_pin = 1'b0;
    logic dpa_locked = 1'b0;
    logic pll_locked = 1'b0;
    logic sda_pull;
    logic [7:0] cfg_input, cfg_loop, cfg_fb_lo, cfg_fb_hi;
    logic [7:0] cfg_phase_ofs, cfg_phase_ctl, cfg_out_en, cfg_osc;
    wire sda_line = sda_m & ~sda_pull;

    int total = 0;
    int fails = 0;
    logic [7:0] buf_q [0:7];
    logic [7:0] exp_sh [0:7];
    logic [7:0] exp_wk [0:7];

    always #10 clk = ~clk;

    clkgen_cfg_target i_clkgen_cfg_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .addr_pin(addr_pin),
        .dpa_locked(dpa_locked), .pll_locked(pll_locked),
        .cfg_input(cfg_input), .cfg_loop(cfg_loop), .cfg_fb_lo(cfg_fb_lo),
        .cfg_fb_hi(cfg_fb_hi), .cfg_phase_ofs(cfg_phase_ofs),
        .cfg_phase_ctl(cfg_phase_ctl), .cfg_out_en(cfg_out_en), .cfg_osc(cfg_osc)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_start;
        sda_m = 1'b1; half; scl_m = 1'b1; half; sda_m = 1'b0; half; scl_m = 1'b0; half;
    endtask

    task automatic send_stop;
        sda_m = 1'b0; half; scl_m = 1'b1; half; sda_m = 1'b1; half; half;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; half; scl_m = 1'b1; half; scl_m = 1'b0;
        end
        sda_m = 1'b1; half; scl_m = 1'b1; half; nack = sda_line; scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; half; scl_m = 1'b1; half; b[i] = sda_line; scl_m = 1'b0;
        end
        sda_m = ~give_ack; half; scl_m = 1'b1; half; scl_m = 1'b0;
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {6'b010011, addr_pin, rd};
    endfunction

    // Sequential write of n bytes from buf_q; ACK of every byte checked (R2)
    task automatic wr_regs(input logic [7:0] idx, input int n);
        logic nk;
        send_start;
        send_byte(dev(1'b0), nk); check("R2 addr ack", {15'd0, nk}, 16'd0);
        send_byte(idx, nk);       check("R2 index ack", {15'd0, nk}, 16'd0);
        for (int i = 0; i < n; i++) begin
            send_byte(buf_q[i], nk); check("R2 data ack", {15'd0, nk}, 16'd0);
        end
        send_stop;
    endtask

    task automatic wr1(input logic [7:0] idx, input logic [7:0] d);
        buf_q[0] = d;
        wr_regs(idx, 1);
    endtask

    task automatic rd_regs(input logic [7:0] idx, input int n);
        logic nk;
        logic [7:0] b;
        send_start;
        send_byte(dev(1'b0), nk);
        send_byte(idx, nk);
        send_start;
        send_byte(dev(1'b1), nk); check("R4 read addr ack", {15'd0, nk}, 16'd0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            buf_q[i] = b;
        end
        half;
        check("R4 released after NACK", {15'd0, sda_pull}, 16'd0);
        send_stop;
    endtask

    task automatic check_outputs(input string req);
        check({req, " idx0"}, {8'd0, cfg_input},     {8'd0, exp_sh[0]});
        check({req, " idx1"}, {8'd0, cfg_loop},      {8'd0, exp_wk[1]});
        check({req, " idx2"}, {8'd0, cfg_fb_lo},     {8'd0, exp_wk[2]});
        check({req, " idx3"}, {8'd0, cfg_fb_hi},     {8'd0, exp_wk[3]});
        check({req, " idx4"}, {8'd0, cfg_phase_ofs}, {8'd0, exp_sh[4]});
        check({req, " idx5"}, {8'd0, cfg_phase_ctl}, {8'd0, exp_wk[5]});
        check({req, " idx6"}, {8'd0, cfg_out_en},    {8'd0, exp_sh[6]});
        check({req, " idx7"}, {8'd0, cfg_osc},       {8'd0, exp_sh[7]});
    endtask

    function automatic logic [7:0] keep_mask(input int i);
        if (i == 1) return 8'h37;
        if (i == 3) return 8'h0F;
        return 8'hFF;
    endfunction

    task automatic commit(input logic [7:0] code);
        wr1(8'h08, code);
        if (code[7:4] == 4'h5) for (int i = 1; i <= 3; i++) exp_wk[i] = exp_sh[i];
        if (code[3:0] == 4'hA) exp_wk[5] = exp_sh[5];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic nk;
        exp_sh[0] = 8'h41; exp_sh[1] = 8'h00; exp_sh[2] = 8'hFF; exp_sh[3] = 8'h0F;
        exp_sh[4] = 8'h80; exp_sh[5] = 8'h03; exp_sh[6] = 8'h00; exp_sh[7] = 8'h80;
        for (int i = 0; i < 8; i++) exp_wk[i] = exp_sh[i];
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5: reset outputs and readback
        check("R5 sda idle", {15'd0, sda_pull}, 16'd0);
        check_outputs("R5 reset");
        rd_regs(8'h00, 8);
        for (int i = 0; i < 8; i++) check("R5 R4 reset readback", {8'd0, buf_q[i]}, {8'd0, exp_sh[i]});

        // R6: shadow write not visible at output, visible on readback
        wr1(8'h02, 8'h34); exp_sh[2] = 8'h34;
        check("R6 fb_lo held", {8'd0, cfg_fb_lo}, 16'h00FF);
        rd_regs(8'h02, 1);
        check("R6 shadow readback", {8'd0, buf_q[0]}, 16'h0034);
        // R7: PLL commit only
        wr1(8'h05, 8'h01); exp_sh[5] = 8'h01;
        commit(8'h50);
        check("R7 pll commit fb_lo", {8'd0, cfg_fb_lo}, 16'h0034);
        check("R7 pll commit leaves dpa", {8'd0, cfg_phase_ctl}, 16'h0003);
        commit(8'h77);
        check_outputs("R7 no-op code");
        commit(8'h3A);
        check("R7 dpa commit", {8'd0, cfg_phase_ctl}, 16'h0001);

        // R9: reserved bits
        wr1(8'h01, 8'hFF); exp_sh[1] = 8'h37;
        wr1(8'h03, 8'hFF); exp_sh[3] = 8'h0F;
        commit(8'h5A);
        check("R9 loop reserved", {8'd0, cfg_loop}, 16'h0037);
        check("R9 fb_hi reserved", {8'd0, cfg_fb_hi}, 16'h000F);
        rd_regs(8'h01, 3);
        check("R9 loop readback", {8'd0, buf_q[0]}, 16'h0037);
        check("R9 fb_hi readback", {8'd0, buf_q[2]}, 16'h000F);

        // R3 R12 R6 R7: sweep of sequential writes over indices 0..7
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 8; i++) begin
                buf_q[i] = 8'((k * 53 + i * 29 + 7) & 255);
                exp_sh[i] = buf_q[i] & keep_mask(i);
            end
            wr_regs(8'h00, 8);
            check_outputs("R3 R12 R6 sweep write");
            rd_regs(8'h00, 8);
            for (int i = 0; i < 8; i++) check("R3 R4 sweep readback", {8'd0, buf_q[i]}, {8'd0, exp_sh[i]});
            commit((k % 2 == 0) ? 8'h5A : 8'h05);
            check_outputs("R7 sweep commit");
        end

        // R8: read-only indices and lock flags
        for (int c = 0; c < 4; c++) begin
            dpa_locked = c[0]; pll_locked = c[1];
            rd_regs(8'h10, 3);
            check("R8 version", {8'd0, buf_q[0]}, 16'h0018);
            check("R8 revision", {8'd0, buf_q[1]}, 16'h0001);
            check("R8 status", {8'd0, buf_q[2]}, {14'd0, c[1], c[0]});
        end
        buf_q[0] = 8'hAA; buf_q[1] = 8'hAA; buf_q[2] = 8'hFF;
        wr_regs(8'h10, 3);
        rd_regs(8'h10, 2);
        check("R8 version after write", {8'd0, buf_q[0]}, 16'h0018);
        check("R8 revision after write", {8'd0, buf_q[1]}, 16'h0001);

        // R10: command index and unimplemented indices
        rd_regs(8'h08, 1);
        check("R10 cmd reads zero", {8'd0, buf_q[0]}, 16'h0000);
        wr1(8'h20, 8'h5A);
        rd_regs(8'h20, 1);
        check("R10 unimplemented reads zero", {8'd0, buf_q[0]}, 16'h0000);
        check_outputs("R10 unimplemented write ignored");

        // R1: wrong address ignored; then pin selects the other address
        send_start;
        send_byte(8'h4E, nk);
        check("R1 no ack other address", {15'd0, nk}, 16'd1);
        send_byte(8'h06, nk);
        send_byte(8'hC3, nk);
        send_stop;
        check("R1 ignored write", {8'd0, cfg_out_en}, {8'd0, exp_sh[6]});
        addr_pin = 1'b1;
        wr1(8'h06, 8'hC3); exp_sh[6] = 8'hC3;
        check("R1 pin high address", {8'd0, cfg_out_en}, 16'h00C3);
        rd_regs(8'h06, 1);
        check("R1 pin high read", {8'd0, buf_q[0]}, 16'h00C3);
        addr_pin = 1'b0;

        // R11: STOP in the middle of the address byte
        send_start;
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b0; half; scl_m = 1'b1; half; scl_m = 1'b0;
        end
        send_stop;
        check("R11 released", {15'd0, sda_pull}, 16'd0);
        wr1(8'h04, 8'h2D); exp_sh[4] = 8'h2D;
        check("R11 recovers", {8'd0, cfg_phase_ofs}, 16'h002D);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule